// File: doc/BRIEF.md
# Boot Image Header Checker

This block sits between a download transport and on-chip RAM. It takes a boot image as a byte stream with a valid/ready handshake and reads a 16-byte header at the front. It checks the header, then passes every payload byte to a RAM write port. The first payload byte lands at address 0, because the image runs from address zero.

The header begins with a signature byte of 0xDA. The next byte is a hash-mode byte, and 0xFF in that byte means no hash is in use. Two bytes follow that hold the image size, least significant byte first. The size counts 512-byte frames, and the count covers the payload plus the 16 header bytes. Four hash bytes and eight reserved bytes complete the header. The block does not compute a hash. It only decodes whether a hash is active and keeps the four hash bytes.

When the declared payload has been written, the block raises `done` and gives a one-cycle `jump` pulse. A bad header moves the block into a sticky error state. A synchronous restart input clears it so that a new download can begin.

Top module: `boot_hdr_chk`

## Requirements
- R1: After reset, and in the cycle after a `restart` pulse, `done`, `err`, `overrun`, `jump` and `hash_active` are low. The next accepted byte is treated as header byte 0.
- R2: If header byte 0 is not 0xDA, the block enters the error state (`err` high). It writes nothing to RAM.
- R3: If header byte 1 is 0xFF, `hash_active` stays low and `hash_val` reads zero. This holds whatever values header bytes 4 to 7 carry, and the image is still accepted.
- R4: If header byte 1 is any value other than 0xFF, `hash_active` goes high. `hash_val` then holds header bytes 4 to 7, with byte 4 in bits 7:0 and byte 7 in bits 31:24.
- R5: `blk_count` holds header bytes 2 (bits 7:0) and 3 (bits 15:8). A count of zero puts the block into the error state.
- R6: The 16 header bytes are never written to RAM. Payload byte k (counting from 0) is written with `wr_addr` = k and `wr_data` equal to the byte. `wr_en` is high in the same cycle the byte is accepted.
- R7: The payload length is `blk_count`*512 − 16 bytes. In the cycle after the last payload byte is accepted, `done` goes high and `jump` is high for exactly one cycle. `done` is low before that point.
- R8: Bytes accepted after `done` cause no RAM write. They set the sticky `overrun` flag, and `done` stays high.
- R9: In the error state, bytes are accepted but not written, and a new 0xDA byte does not leave the state. Only `restart` or reset clears `err`.
- R10: `in_ready` is high in every cycle except one in which `restart` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous return to idle |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 16+FRAME_LOG2 | RAM byte address |
| wr_data | output | 8 | RAM write byte |
| blk_count | output | 16 | Declared size in frames |
| hash_active | output | 1 | Header requests a hash |
| hash_val | output | 32 | Stored hash bytes |
| done | output | 1 | Declared payload fully written |
| jump | output | 1 | One-cycle execute request |
| err | output | 1 | Header rejected |
| overrun | output | 1 | Bytes arrived after completion |

## Verification
The bench sends complete images of one, two and three frames, both with hashing on and with hashing off. It checks every payload write, so an off-by-one in the length arithmetic shows up directly. A design that forgot the 16 header bytes in the length would raise `done` 16 bytes late. A design that wrote header bytes would shift every address. Non-0xFF hash bytes are also sent while hashing is inactive, which catches a design that stores them anyway.

Error entry is tested with a bad signature and with a zero frame count. After error entry the bench sends a fresh 0xDA, which catches a design that leaves the error state without `restart`. Bytes sent after completion show whether a design writes past the image or fails to set `overrun`.

// File: rtl/boot_hdr_chk.sv
module boot_hdr_chk #(
  parameter int FRAME_LOG2 = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  output logic                   wr_en,
  output logic [15+FRAME_LOG2:0] wr_addr,
  output logic [7:0]             wr_data,
  output logic [15:0]            blk_count,
  output logic                   hash_active,
  output logic [31:0]            hash_val,
  output logic                   done,
  output logic                   jump,
  output logic                   err,
  output logic                   overrun
);
  localparam int AW = 16 + FRAME_LOG2;
  localparam int HDR_LEN = 16;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_DONE, S_ERR} st_t;
  st_t st;
  logic [3:0]    hidx;
  logic [AW-1:0] pcnt;

  wire take = in_valid & in_ready;
  wire [AW-1:0] last_idx = {blk_count, {FRAME_LOG2{1'b0}}} - AW'(HDR_LEN + 1);

  assign in_ready = ~restart;
  assign wr_en    = take && (st == S_PAY);
  assign wr_addr  = pcnt;
  assign wr_data  = in_data;
  assign done     = (st == S_DONE);
  assign err      = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st          <= S_IDLE;
      hidx        <= '0;
      pcnt        <= '0;
      blk_count   <= '0;
      hash_active <= 1'b0;
      hash_val    <= '0;
      jump        <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      jump <= 1'b0;
      if (take) begin
        case (st)
          S_IDLE: begin
            hidx <= 4'd1;
            st   <= (in_data == 8'hDA) ? S_HDR : S_ERR;
          end
          S_HDR: begin
            hidx <= hidx + 4'd1;
            case (hidx)
              4'd1: hash_active <= (in_data != 8'hFF);
              4'd2: blk_count[7:0] <= in_data;
              4'd3: begin
                blk_count[15:8] <= in_data;
                if ({in_data, blk_count[7:0]} == 16'd0) st <= S_ERR;
              end
              4'd4, 4'd5, 4'd6, 4'd7:
                if (hash_active) hash_val <= {in_data, hash_val[31:8]};
              4'd15: begin
                st   <= S_PAY;
                pcnt <= '0;
              end
              default: ;
            endcase
          end
          S_PAY: begin
            pcnt <= pcnt + AW'(1);
            if (pcnt == last_idx) begin
              st   <= S_DONE;
              jump <= 1'b1;
            end
          end
          S_DONE: overrun <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

module boot_hdr_chk_sva #(
  parameter int AW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          in_valid,
  input logic          in_ready,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done,
  input logic          jump,
  input logic          err,
  input logic          overrun,
  input logic          hash_active,
  input logic [31:0]   hash_val
);
  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!done && !err && !overrun && !jump));

  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en);

  assert_write_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (in_valid && in_ready && !done));

  assert_addr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (wr_en && !restart) |=> (!wr_en || wr_addr == $past(wr_addr) + AW'(1)));

  assert_jump_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> !jump);

  assert_jump_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> jump);

  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_no_hash_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hash_active |-> (hash_val == 32'd0));

  assert_overrun_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> done);
endmodule

bind boot_hdr_chk boot_hdr_chk_sva #(.AW(16 + FRAME_LOG2)) u_sva (
  .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
  .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .done(done),
  .jump(jump), .err(err), .overrun(overrun), .hash_active(hash_active),
  .hash_val(hash_val)
);

// File: tb/boot_hdr_chk_tb.sv
`timescale 1ns/1ps
module boot_hdr_chk_tb;
  localparam int AW = 25;
  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, wr_en, hash_active, done, jump, err, overrun;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [15:0] blk_count;
  logic [31:0] hash_val;
  int errors = 0, checks = 0;
  logic s_wen;
  logic [AW-1:0] s_addr;
  logic [7:0] s_data;
  logic s_rdy;

  always #5 clk = ~clk;

  boot_hdr_chk u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .blk_count(blk_count), .hash_active(hash_active),
    .hash_val(hash_val), .done(done), .jump(jump), .err(err), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #2;
    s_wen = wr_en; s_addr = wr_addr; s_data = wr_data; s_rdy = in_ready;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    #2;
    chk(in_ready == 1'b0, "R10 ready low in restart", 32'(in_ready), 32'd0);
    @(posedge clk);
    #1;
    restart = 1'b0;
    chk({done, err, overrun, jump, hash_active} == 5'd0, "R1 flags after restart",
        32'({done, err, overrun, jump, hash_active}), 32'd0);
  endtask

  task automatic run_image(input int blocks, input logic [7:0] b1, input logic [31:0] hsh, input int extra);
    int n;
    logic [31:0] exph;
    do_restart();
    put(8'hDA);
    chk(s_wen == 1'b0 && s_rdy, "R6 no write of header", 32'(s_wen), 32'd0);
    put(b1);
    put(blocks[7:0]);
    put(blocks[15:8]);
    for (int k = 0; k < 4; k++) begin
      put(hsh[8*k +: 8]);
      chk(s_wen == 1'b0, "R6 no write of header", 32'(s_wen), 32'd0);
    end
    for (int k = 0; k < 8; k++) begin
      put(8'h5A);
      chk(s_wen == 1'b0, "R6 no write of reserved", 32'(s_wen), 32'd0);
    end
    exph = (b1 != 8'hFF) ? hsh : 32'd0;
    chk(hash_active == (b1 != 8'hFF), (b1 != 8'hFF) ? "R4 hash active" : "R3 hash inactive",
        32'(hash_active), 32'(b1 != 8'hFF));
    chk(hash_val == exph, (b1 != 8'hFF) ? "R4 hash value" : "R3 hash value zero", hash_val, exph);
    chk(blk_count == 16'(blocks), "R5 block count", 32'(blk_count), 32'(blocks));
    chk(err == 1'b0, "R5 valid header no err", 32'(err), 32'd0);
    n = blocks * 512 - 16;
    for (int i = 0; i < n; i++) begin
      put(8'((i * 7 + blocks) & 8'hFF));
      chk(s_wen == 1'b1, "R6 payload write strobe", 32'(s_wen), 32'd1);
      chk(s_addr == AW'(i), "R6 payload address", 32'(s_addr), 32'(i));
      chk(s_data == 8'((i * 7 + blocks) & 8'hFF), "R6 payload data", 32'(s_data), 32'((i * 7 + blocks) & 8'hFF));
      if (i == n - 2) chk(done == 1'b0, "R7 done not early", 32'(done), 32'd0);
      if (i == n - 1) begin
        chk(done == 1'b1, "R7 done at length", 32'(done), 32'd1);
        chk(jump == 1'b1, "R7 jump pulse", 32'(jump), 32'd1);
      end
    end
    @(posedge clk); #1;
    chk(jump == 1'b0, "R7 jump one cycle", 32'(jump), 32'd0);
    for (int k = 0; k < extra; k++) begin
      put(8'hDA);
      chk(s_wen == 1'b0, "R8 no write after done", 32'(s_wen), 32'd0);
    end
    chk(overrun == (extra > 0), "R8 overrun flag", 32'(overrun), 32'(extra > 0));
    chk(done == 1'b1, "R8 done held", 32'(done), 32'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    chk({done, err, overrun, jump, hash_active} == 5'd0, "R1 reset flags",
        32'({done, err, overrun, jump, hash_active}), 32'd0);
    chk(in_ready == 1'b1, "R10 ready after reset", 32'(in_ready), 32'd1);
    chk(hash_val == 32'd0 && blk_count == 16'd0, "R1 reset fields", hash_val, 32'd0);

    for (int b = 1; b <= 3; b++) begin
      run_image(b, 8'hFF, 32'h78563412, b - 1);
      run_image(b, 8'h3C, 32'hA1B2C3D4 + 32'(b), 2 - b + 1);
    end

    do_restart();
    put(8'hD9);
    chk(s_wen == 1'b0, "R2 bad signature no write", 32'(s_wen), 32'd0);
    chk(err == 1'b1, "R2 bad signature err", 32'(err), 32'd1);
    put(8'hDA);
    chk(err == 1'b1, "R9 err sticky on DA", 32'(err), 32'd1);
    for (int k = 0; k < 20; k++) begin
      put(8'(k));
      chk(s_wen == 1'b0 && s_rdy == 1'b1, "R9 err drops bytes", 32'({s_wen, s_rdy}), 32'd1);
    end
    chk(err == 1'b1 && done == 1'b0, "R9 err held", 32'({err, done}), 32'd2);

    do_restart();
    chk(err == 1'b0, "R1 restart clears err", 32'(err), 32'd0);
    put(8'hDA); put(8'hFF); put(8'h00); put(8'h00);
    chk(err == 1'b1, "R5 zero count err", 32'(err), 32'd1);
    for (int k = 0; k < 30; k++) begin
      put(8'hDA);
      chk(s_wen == 1'b0, "R9 no write after zero count", 32'(s_wen), 32'd0);
    end

    run_image(1, 8'h00, 32'h0BADF00D, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule